// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source stage of a two-level interrupt controller. It keeps one state entry per interrupt source: a target server, a live priority, a remembered priority and four status bits. Sources are either level-sensitive or message-style, chosen per source by a mode input. Sources are numbered from a base value, and every number that crosses the block's edge is in that numbering. The block turns input activity into delivery requests for the presentation stage. It holds a request back when the source is masked and re-issues it later, so that no interrupt is lost.

Priority 0xFF means "masked". The presentation stage can refuse a delivery (reject), signal completion (end-of-interrupt) and ask for every outstanding interrupt to be offered again (resend). A configuration port sets and reads the target and priority, and switches a source off or back on. Deliveries leave through a valid/ready handshake.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every entry has server 0, live and remembered priority 0xFF and all status bits clear, and no delivery is offered. The level/message mode comes from `src_is_level`, and reset does not touch it.
- R2: A message source (mode 0) that sees `src_line` high in a cycle while its priority is 0xFF records a masked-pending event and offers no delivery.
- R3: A message source that sees `src_line` high while its priority is not 0xFF requests a delivery. The delivery carries number `SRC_BASE`+index, the entry's server and the entry's priority.
- R4: For a level source (mode 1), a change of `src_line` updates its asserted bit. The source then requests a delivery and sets its sent bit only if the priority is not 0xFF, asserted is set and sent is clear. While sent stays set, a line held high produces no further delivery.
- R5: A reject naming a valid source sets that source's rejected bit and clears its sent bit, whatever its mode.
- R6: An end-of-interrupt clears the sent bit of a level source and has no effect on a message source. It does not deliver anything by itself.
- R7: A resend request starts a scan that visits one source per cycle, from index 0 up to the last. A message source with rejected set has rejected cleared, and it is redelivered if its priority is not 0xFF. A level source applies the R4 delivery rule.
- R8: Configuration op 0 (set) stores server, priority and remembered priority. After the store, a message source with masked-pending and a priority other than 0xFF clears masked-pending and is delivered. A level source applies the R4 rule.
- R9: Op 2 (off) copies the live priority into the remembered one and sets the live priority to 0xFF. Op 3 (on) restores the live priority from the remembered one, then applies the R8 post-store rule.
- R10: Every accepted configuration access (`cfg_valid` and `cfg_ready`) produces `cfg_done` in the following cycle, and in no other cycle. For a valid number, `rd_server` and `rd_prio` then show the entry's server and priority; op 1 (get) changes nothing.
- R11: A number outside `SRC_BASE` to `SRC_BASE+NUM_SRC-1` returns `cfg_err`, and the access changes no entry.
- R12: Requests from several sources are offered one at a time, lowest index first. An offered delivery stays valid until `dlv_ready` takes it. Repeated requests from one source before it is taken merge into one delivery.
- R13: `cfg_ready` is low from the cycle after a resend request is accepted until the scan is over, which is `NUM_SRC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | NUM_SRC | Per-source interrupt lines |
| src_is_level | input | NUM_SRC | Per-source mode: 1 level, 0 message |
| cfg_valid | input | 1 | Configuration access request |
| cfg_ready | output | 1 | Configuration access can be accepted |
| cfg_op | input | 2 | 0 set, 1 get, 2 off, 3 on |
| cfg_num | input | NUM_W | Source number of the access |
| cfg_server | input | SRV_W | Server for op set |
| cfg_prio | input | 8 | Priority for op set |
| cfg_done | output | 1 | Access completed (one cycle) |
| cfg_err | output | 1 | Completed access named an invalid source |
| rd_server | output | SRV_W | Entry server after the access |
| rd_prio | output | 8 | Entry priority after the access |
| rej_valid | input | 1 | Reject pulse from presentation stage |
| rej_num | input | NUM_W | Rejected source number |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_num | input | NUM_W | Completed source number |
| resend_req | input | 1 | Request to re-offer outstanding interrupts |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Presentation stage takes the delivery |
| dlv_num | output | NUM_W | Delivered source number |
| dlv_server | output | SRV_W | Delivered target server |
| dlv_prio | output | 8 | Delivered priority |

## Verification
The bench goes after the points where an interrupt could be lost or duplicated. A masked message event must come out when the source is enabled again. A design that dropped the pending bit would never deliver it. A level line held high must be delivered once, not once per cycle, and must not come back after end-of-interrupt until a resend. A rejected source must be redelivered by the next resend and only by that one. A scan that skipped the rejected bit would deliver nothing, and one that never cleared it would deliver again on every resend. With the delivery port stalled, two simultaneous events must come out in index order without being dropped, and configuration must stay blocked for exactly the length of the scan.

// File: rtl/isc_pkg.sv
package isc_pkg;

   localparam int PRIO_W = 8;
   localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

   typedef enum logic [1:0] {
      OP_SET = 2'd0,
      OP_GET = 2'd1,
      OP_OFF = 2'd2,
      OP_ON  = 2'd3
   } cfg_op_e;

endpackage

// File: rtl/isc_entry.sv
module isc_entry
   import isc_pkg::*;
#(
   parameter int SRV_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_level,
   input  logic              line,
   input  logic              fire,
   input  logic              rej_hit,
   input  logic              eoi_hit,
   input  logic              cfg_hit,
   input  cfg_op_e           cfg_op,
   input  logic [SRV_W-1:0]  cfg_srv,
   input  logic [PRIO_W-1:0] cfg_pri,
   input  logic              scan_hit,
   output logic [SRV_W-1:0]  srv,
   output logic [PRIO_W-1:0] pri,
   output logic              want
);

   typedef struct packed {
      logic [SRV_W-1:0]  srv;
      logic [PRIO_W-1:0] pri;
      logic [PRIO_W-1:0] sav;
      logic              asrt;
      logic              sent;
      logic              rjct;
      logic              mpend;
      logic              want;
      logic              lineq;
   } st_t;

   st_t cur, nxt;

   function automatic st_t level_rule(st_t s);
      st_t r;
      r = s;
      if (r.pri != PRIO_MASKED && r.asrt && !r.sent) begin
         r.sent = 1'b1;
         r.want = 1'b1;
      end
      return r;
   endfunction

   function automatic st_t after_store(st_t s, logic lvl);
      st_t r;
      r = s;
      if (lvl) begin
         r = level_rule(r);
      end else if (r.mpend && r.pri != PRIO_MASKED) begin
         r.mpend = 1'b0;
         r.want  = 1'b1;
      end
      return r;
   endfunction

   always_comb begin
      nxt = cur;
      // a taken delivery retires the request first
      if (fire) nxt.want = 1'b0;
      // line activity
      if (is_level) begin
         nxt.asrt = line;
         if (line != cur.lineq) nxt = level_rule(nxt);
      end else if (line) begin
         if (nxt.pri == PRIO_MASKED) nxt.mpend = 1'b1;
         else                        nxt.want  = 1'b1;
      end
      nxt.lineq = line;
      // presentation stage feedback
      if (rej_hit) begin
         nxt.rjct = 1'b1;
         nxt.sent = 1'b0;
      end
      if (eoi_hit && is_level) nxt.sent = 1'b0;
      // configuration
      if (cfg_hit) begin
         unique case (cfg_op)
            OP_SET: begin
               nxt.srv = cfg_srv;
               nxt.pri = cfg_pri;
               nxt.sav = cfg_pri;
            end
            OP_OFF: begin
               nxt.sav = nxt.pri;
               nxt.pri = PRIO_MASKED;
            end
            OP_ON:   nxt.pri = nxt.sav;
            default: ;
         endcase
         if (cfg_op != OP_GET) nxt = after_store(nxt, is_level);
      end
      // resend scan visit
      if (scan_hit) begin
         if (is_level) begin
            nxt = level_rule(nxt);
         end else if (nxt.rjct) begin
            nxt.rjct = 1'b0;
            if (nxt.pri != PRIO_MASKED) nxt.want = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur.srv   <= '0;
         cur.pri   <= PRIO_MASKED;
         cur.sav   <= PRIO_MASKED;
         cur.asrt  <= 1'b0;
         cur.sent  <= 1'b0;
         cur.rjct  <= 1'b0;
         cur.mpend <= 1'b0;
         cur.want  <= 1'b0;
         cur.lineq <= 1'b0;
      end else begin
         cur <= nxt;
      end
   end

   assign srv  = cur.srv;
   assign pri  = cur.pri;
   assign want = cur.want;

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/isc_scan.sv
module isc_scan #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (busy) begin
         if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end
   end

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
   import isc_pkg::*;
#(
   parameter int NUM_SRC  = 8,
   parameter int SRC_BASE = 16,
   parameter int NUM_W    = 10,
   parameter int SRV_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_line,
   input  logic [NUM_SRC-1:0] src_is_level,
   input  logic               cfg_valid,
   output logic               cfg_ready,
   input  logic [1:0]         cfg_op,
   input  logic [NUM_W-1:0]   cfg_num,
   input  logic [SRV_W-1:0]   cfg_server,
   input  logic [7:0]         cfg_prio,
   output logic               cfg_done,
   output logic               cfg_err,
   output logic [SRV_W-1:0]   rd_server,
   output logic [7:0]         rd_prio,
   input  logic               rej_valid,
   input  logic [NUM_W-1:0]   rej_num,
   input  logic               eoi_valid,
   input  logic [NUM_W-1:0]   eoi_num,
   input  logic               resend_req,
   output logic               dlv_valid,
   input  logic               dlv_ready,
   output logic [NUM_W-1:0]   dlv_num,
   output logic [SRV_W-1:0]   dlv_server,
   output logic [7:0]         dlv_prio
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [31:0] LO = 32'(SRC_BASE);
   localparam logic [31:0] HI = 32'(SRC_BASE + NUM_SRC);

   initial begin
      assert (NUM_SRC >= 2) else $error("NUM_SRC must be at least 2");
      assert (SRV_W >= 1) else $error("SRV_W must be positive");
      assert (SRC_BASE + NUM_SRC <= (1 << NUM_W))
         else $error("source numbers do not fit NUM_W");
   end

   function automatic logic in_range(logic [NUM_W-1:0] n);
      return (32'(n) >= LO) && (32'(n) < HI);
   endfunction

   function automatic logic [IDX_W-1:0] to_idx(logic [NUM_W-1:0] n);
      logic [31:0] d;
      d = 32'(n) - LO;
      return d[IDX_W-1:0];
   endfunction

   logic [SRV_W-1:0]  srv_arr [NUM_SRC];
   logic [PRIO_W-1:0] pri_arr [NUM_SRC];
   logic [NUM_SRC-1:0] want_vec;
   logic [NUM_SRC-1:0] fire_vec, rej_vec, eoi_vec, cfg_vec, scan_vec;

   logic             scan_busy;
   logic [IDX_W-1:0] scan_idx;
   logic             pick_any;
   logic [IDX_W-1:0] pick_idx;

   logic             cfg_acc, cfg_ok, rej_ok, eoi_ok;
   logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx;
   cfg_op_e          op;

   logic             done_q, err_q, rdok_q;
   logic [IDX_W-1:0] rdidx_q;

   assign cfg_ready = !scan_busy;
   assign cfg_acc   = cfg_valid && cfg_ready;
   assign cfg_ok    = in_range(cfg_num);
   assign cfg_idx   = to_idx(cfg_num);
   assign rej_ok    = rej_valid && in_range(rej_num);
   assign rej_idx   = to_idx(rej_num);
   assign eoi_ok    = eoi_valid && in_range(eoi_num);
   assign eoi_idx   = to_idx(eoi_num);
   assign op        = cfg_op_e'(cfg_op);

   isc_scan #(.N(NUM_SRC), .IDX_W(IDX_W)) i_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .start (resend_req),
      .busy  (scan_busy),
      .idx   (scan_idx)
   );

   isc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) i_pick (
      .req (want_vec),
      .any (pick_any),
      .idx (pick_idx)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign fire_vec[g] = pick_any && dlv_ready && (pick_idx == IDX_W'(g));
      assign rej_vec[g]  = rej_ok && (rej_idx == IDX_W'(g));
      assign eoi_vec[g]  = eoi_ok && (eoi_idx == IDX_W'(g));
      assign cfg_vec[g]  = cfg_acc && cfg_ok && (cfg_idx == IDX_W'(g));
      assign scan_vec[g] = scan_busy && (scan_idx == IDX_W'(g));

      isc_entry #(.SRV_W(SRV_W)) i_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .is_level (src_is_level[g]),
         .line     (src_line[g]),
         .fire     (fire_vec[g]),
         .rej_hit  (rej_vec[g]),
         .eoi_hit  (eoi_vec[g]),
         .cfg_hit  (cfg_vec[g]),
         .cfg_op   (op),
         .cfg_srv  (cfg_server),
         .cfg_pri  (cfg_prio),
         .scan_hit (scan_vec[g]),
         .srv      (srv_arr[g]),
         .pri      (pri_arr[g]),
         .want     (want_vec[g])
      );
   end

   assign dlv_valid  = pick_any;
   assign dlv_num    = NUM_W'(SRC_BASE) + NUM_W'(pick_idx);
   assign dlv_server = srv_arr[pick_idx];
   assign dlv_prio   = pri_arr[pick_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdok_q  <= 1'b0;
         rdidx_q <= '0;
      end else begin
         done_q  <= cfg_acc;
         err_q   <= cfg_acc && !cfg_ok;
         rdok_q  <= cfg_acc && cfg_ok;
         rdidx_q <= cfg_idx;
      end
   end

   assign cfg_done  = done_q;
   assign cfg_err   = err_q;
   assign rd_server = rdok_q ? srv_arr[rdidx_q] : '0;
   assign rd_prio   = rdok_q ? pri_arr[rdidx_q] : '0;

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
   parameter int NUM_SRC  = 8,
   parameter int SRC_BASE = 16,
   parameter int NUM_W    = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_valid,
   input logic             cfg_ready,
   input logic [NUM_W-1:0] cfg_num,
   input logic             cfg_done,
   input logic             cfg_err,
   input logic             resend_req,
   input logic             dlv_valid,
   input logic             dlv_ready,
   input logic [NUM_W-1:0] dlv_num
);

   function automatic logic ok_num(logic [NUM_W-1:0] n);
      return (32'(n) >= 32'(SRC_BASE)) && (32'(n) < 32'(SRC_BASE + NUM_SRC));
   endfunction

   a_r12_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && !dlv_ready |=> dlv_valid);

   a_r3_number_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> ok_num(dlv_num));

   a_r10_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && cfg_ready |=> cfg_done);

   a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && cfg_ready) |=> !cfg_done);

   a_r11_error_matches_number: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && cfg_ready |=> (cfg_err == !ok_num($past(cfg_num))));

   a_r13_scan_blocks_config: assert property (@(posedge clk) disable iff (!rst_n)
      resend_req && cfg_ready |=> !cfg_ready);

endmodule

bind irq_src_ctrl isc_checker #(
   .NUM_SRC  (NUM_SRC),
   .SRC_BASE (SRC_BASE),
   .NUM_W    (NUM_W)
) i_isc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_valid  (cfg_valid),
   .cfg_ready  (cfg_ready),
   .cfg_num    (cfg_num),
   .cfg_done   (cfg_done),
   .cfg_err    (cfg_err),
   .resend_req (resend_req),
   .dlv_valid  (dlv_valid),
   .dlv_ready  (dlv_ready),
   .dlv_num    (dlv_num)
);

// File: tb/test_irq_src_ctrl.sv
`timescale 1ns/1ps
module test_irq_src_ctrl;

   localparam int N = 8;
   localparam int BASE = 16;
   localparam int NW = 10;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] src_line = '0;
   logic [N-1:0] src_is_level = 8'b1111_0000;
   logic cfg_valid = 1'b0;
   logic cfg_ready;
   logic [1:0] cfg_op = 2'd0;
   logic [NW-1:0] cfg_num = '0;
   logic [SW-1:0] cfg_server = '0;
   logic [7:0] cfg_prio = '0;
   logic cfg_done, cfg_err;
   logic [SW-1:0] rd_server;
   logic [7:0] rd_prio;
   logic rej_valid = 1'b0;
   logic [NW-1:0] rej_num = '0;
   logic eoi_valid = 1'b0;
   logic [NW-1:0] eoi_num = '0;
   logic resend_req = 1'b0;
   logic dlv_valid;
   logic dlv_ready = 1'b1;
   logic [NW-1:0] dlv_num;
   logic [SW-1:0] dlv_server;
   logic [7:0] dlv_prio;

   always #5 clk = ~clk;

   irq_src_ctrl #(.NUM_SRC(N), .SRC_BASE(BASE), .NUM_W(NW), .SRV_W(SW)) i_irq_src_ctrl (.*);

   int checks = 0;
   int errors = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_srv[N], m_pr[N], m_sv[N];
   bit m_as[N], m_st[N], m_rj[N], m_mp[N], m_w[N], m_lq[N];
   bit m_busy = 0, m_done = 0, m_err = 0, m_rdok = 0;
   int m_sidx = 0, m_rdidx = 0;

   task automatic m_reset();
      for (int i = 0; i < N; i++) begin
         m_srv[i] = 0; m_pr[i] = 255; m_sv[i] = 255;
         m_as[i] = 0; m_st[i] = 0; m_rj[i] = 0; m_mp[i] = 0; m_w[i] = 0; m_lq[i] = 0;
      end
      m_busy = 0; m_sidx = 0; m_done = 0; m_err = 0; m_rdok = 0;
   endtask

   task automatic lvl_try(int i);
      if (m_pr[i] != 255 && m_as[i] && !m_st[i]) begin
         m_st[i] = 1; m_w[i] = 1;
      end
   endtask

   function automatic int first_want();
      for (int i = 0; i < N; i++) if (m_w[i]) return i;
      return -1;
   endfunction

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reset();
      end else begin
         int f, ci;
         bit acc, cok;
         f   = dlv_ready ? first_want() : -1;
         acc = cfg_valid && !m_busy;
         cok = int'(cfg_num) >= BASE && int'(cfg_num) < BASE + N;
         ci  = int'(cfg_num) - BASE;
         m_done = acc; m_err = acc && !cok; m_rdok = acc && cok; m_rdidx = ci;
         for (int i = 0; i < N; i++) begin
            if (f == i) m_w[i] = 0;
            if (src_is_level[i]) begin
               m_as[i] = src_line[i];
               if (src_line[i] != m_lq[i]) lvl_try(i);
            end else if (src_line[i]) begin
               if (m_pr[i] == 255) m_mp[i] = 1; else m_w[i] = 1;
            end
            m_lq[i] = src_line[i];
            if (rej_valid && int'(rej_num) == BASE + i) begin m_rj[i] = 1; m_st[i] = 0; end
            if (eoi_valid && int'(eoi_num) == BASE + i && src_is_level[i]) m_st[i] = 0;
            if (acc && cok && ci == i) begin
               case (cfg_op)
                  2'd0: begin m_srv[i] = int'(cfg_server); m_pr[i] = int'(cfg_prio); m_sv[i] = int'(cfg_prio); end
                  2'd2: begin m_sv[i] = m_pr[i]; m_pr[i] = 255; end
                  2'd3: m_pr[i] = m_sv[i];
                  default: ;
               endcase
               if (cfg_op != 2'd1) begin
                  if (src_is_level[i]) lvl_try(i);
                  else if (m_mp[i] && m_pr[i] != 255) begin m_mp[i] = 0; m_w[i] = 1; end
               end
            end
            if (m_busy && m_sidx == i) begin
               if (src_is_level[i]) lvl_try(i);
               else if (m_rj[i]) begin
                  m_rj[i] = 0;
                  if (m_pr[i] != 255) m_w[i] = 1;
               end
            end
         end
         if (m_busy) begin
            if (m_sidx == N - 1) begin m_busy = 0; m_sidx = 0; end
            else m_sidx++;
         end else if (resend_req) begin
            m_busy = 1; m_sidx = 0;
         end
      end
   end

   // ---------------- per-cycle comparison and delivery log ----------------
   int dcnt = 0;
   int lastn = 0, lasts = 0, lastp = 0;
   int logq[$];

   always @(negedge clk) begin
      if (rst_n) begin
         int e;
         e = first_want();
         chk(dlv_valid == (e >= 0), "R12 valid", int'(dlv_valid), int'(e >= 0));
         if (e >= 0) begin
            chk(int'(dlv_num) == BASE + e, "R3 number", int'(dlv_num), BASE + e);
            chk(int'(dlv_server) == m_srv[e], "R3 server", int'(dlv_server), m_srv[e]);
            chk(int'(dlv_prio) == m_pr[e], "R3 priority", int'(dlv_prio), m_pr[e]);
         end
         chk(cfg_ready == !m_busy, "R13 ready", int'(cfg_ready), int'(!m_busy));
         chk(cfg_done == m_done, "R10 done", int'(cfg_done), int'(m_done));
         if (m_done) chk(cfg_err == m_err, "R11 error", int'(cfg_err), int'(m_err));
         if (m_rdok) begin
            chk(int'(rd_server) == m_srv[m_rdidx], "R10 server", int'(rd_server), m_srv[m_rdidx]);
            chk(int'(rd_prio) == m_pr[m_rdidx], "R10 priority", int'(rd_prio), m_pr[m_rdidx]);
         end
         if (dlv_valid && dlv_ready) begin
            dcnt++;
            lastn = int'(dlv_num); lasts = int'(dlv_server); lastp = int'(dlv_prio);
            logq.push_back(lastn);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic cfg(int op, int num, int srv, int pri);
      while (!cfg_ready) tick();
      cfg_valid = 1; cfg_op = 2'(op); cfg_num = NW'(num);
      cfg_server = SW'(srv); cfg_prio = 8'(pri);
      tick();
      cfg_valid = 0;
   endtask

   task automatic pulse_line(int idx);
      src_line[idx] = 1'b1; tick(); src_line[idx] = 1'b0;
   endtask

   task automatic reject(int num);
      rej_valid = 1; rej_num = NW'(num); tick(); rej_valid = 0;
   endtask

   task automatic eoi(int num);
      eoi_valid = 1; eoi_num = NW'(num); tick(); eoi_valid = 0;
   endtask

   task automatic resend();
      while (!cfg_ready) tick();
      resend_req = 1; tick(); resend_req = 0;
      tick(N + 3);
   endtask

   task automatic expect_dlv(int d0, int n, int num, int srv, int pri, string tag);
      chk(dcnt - d0 == n, tag, dcnt - d0, n);
      if (n > 0 && dcnt - d0 == n) begin
         chk(lastn == num, tag, lastn, num);
         chk(lasts == srv, tag, lasts, srv);
         chk(lastp == pri, tag, lastp, pri);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int d0, cyc;
      tick(3);
      rst_n = 1;
      tick();

      // R1: reset state
      chk(dlv_valid == 0, "R1 no delivery", int'(dlv_valid), 0);
      cfg(1, BASE + 5, 0, 0);
      chk(cfg_done && !cfg_err, "R1 get done", int'(cfg_err), 0);
      chk(rd_server == 0, "R1 server", int'(rd_server), 0);
      chk(rd_prio == 8'hFF, "R1 priority", int'(rd_prio), 255);

      // R2 then R8: masked message event, released by a set
      d0 = dcnt; pulse_line(0); tick(2);
      expect_dlv(d0, 0, 0, 0, 0, "R2 masked event");
      d0 = dcnt; cfg(0, BASE + 0, 3, 5); tick(2);
      expect_dlv(d0, 1, BASE + 0, 3, 5, "R8 pending released");

      // R3: message delivery
      d0 = dcnt; cfg(0, BASE + 1, 2, 7); tick(2);
      expect_dlv(d0, 0, 0, 0, 0, "R8 no pending");
      d0 = dcnt; pulse_line(1); tick(2);
      expect_dlv(d0, 1, BASE + 1, 2, 7, "R3 message delivery");

      // R4: level source
      cfg(0, BASE + 4, 1, 4);
      d0 = dcnt; src_line[4] = 1; tick(5);
      expect_dlv(d0, 1, BASE + 4, 1, 4, "R4 level once");

      // R6 and R7: eoi alone does nothing, resend redelivers level
      d0 = dcnt; eoi(BASE + 4); tick(3);
      expect_dlv(d0, 0, 0, 0, 0, "R6 eoi silent");
      d0 = dcnt; resend();
      expect_dlv(d0, 1, BASE + 4, 1, 4, "R7 level resend");

      // R5 and R7: reject message, resend redelivers once
      d0 = dcnt; reject(BASE + 1); resend();
      expect_dlv(d0, 1, BASE + 1, 2, 7, "R5 R7 message resend");
      d0 = dcnt; resend();
      expect_dlv(d0, 0, 0, 0, 0, "R7 rejected cleared");

      // R5: reject on level source
      d0 = dcnt; reject(BASE + 4); resend();
      expect_dlv(d0, 1, BASE + 4, 1, 4, "R5 level reject");

      // R9: off / on
      cfg(2, BASE + 1, 0, 0);
      chk(rd_prio == 8'hFF, "R9 off priority", int'(rd_prio), 255);
      d0 = dcnt; pulse_line(1); tick(2);
      expect_dlv(d0, 0, 0, 0, 0, "R9 off masks");
      cfg(3, BASE + 1, 0, 0);
      chk(rd_prio == 7, "R9 on priority", int'(rd_prio), 7);
      tick(2);
      expect_dlv(d0, 1, BASE + 1, 2, 7, "R9 on releases pending");

      // R11: invalid numbers
      cfg(1, BASE - 1, 0, 0);
      chk(cfg_done && cfg_err, "R11 below range", int'(cfg_err), 1);
      cfg(0, BASE + N, 9, 1);
      chk(cfg_done && cfg_err, "R11 above range", int'(cfg_err), 1);
      cfg(1, BASE + 0, 0, 0);
      chk(rd_server == 3 && rd_prio == 5, "R11 no change", int'(rd_prio), 5);

      // R12: stalled port, two simultaneous events
      cfg(0, BASE + 3, 6, 3);
      cfg(0, BASE + 2, 5, 2);
      dlv_ready = 0;
      src_line[2] = 1; src_line[3] = 1; tick(); src_line[2] = 0; src_line[3] = 0;
      tick(3);
      chk(dlv_valid && dlv_num == NW'(BASE + 2), "R12 held lowest", int'(dlv_num), BASE + 2);
      d0 = dcnt; dlv_ready = 1; tick(4);
      chk(dcnt - d0 == 2, "R12 both delivered", dcnt - d0, 2);
      if (dcnt - d0 == 2) begin
         chk(logq[d0] == BASE + 2, "R12 order first", logq[d0], BASE + 2);
         chk(logq[d0 + 1] == BASE + 3, "R12 order second", logq[d0 + 1], BASE + 3);
      end

      // R13: scan blocks configuration for N cycles
      resend_req = 1; tick(); resend_req = 0;
      chk(cfg_ready == 0, "R13 blocked", int'(cfg_ready), 0);
      cyc = 0;
      while (!cfg_ready && cyc < 100) begin tick(); cyc++; end
      chk(cyc == N, "R13 scan length", cyc, N);

      src_line[4] = 0;
      tick(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule